// File: doc/BRIEF.md
# Battery Protection Fault Controller

This block is the digital decision core of a battery pack protector. Analog comparators outside it report, for each monitored condition, a trip flag (threshold crossed) and a separate recovery flag (threshold with hysteresis crossed back). The block qualifies each flag with a programmable run-length counter. It keeps one active/inactive fault state per condition and derives the charge-FET and discharge-FET enables from those states. Each fault class has a fixed mapping onto the two FETs.

Two external enable pins, one for charge and one for discharge, are deglitched and handled as faults in their own right. The three overcurrent and short-circuit faults do not use a recovery threshold. They clear through a recovery timer, through the load-removal flag, or only when both have happened, depending on a mode chosen at configuration. All delays and the overcurrent mode are taken from configuration inputs while reset is high. A sticky status register records every fault class seen since the last host clear.

Top module: `bpfc_top`

## Requirements
- R1: A fault at overvoltage (index 0), over-temperature while charging (6) or under-temperature while charging (8), or a qualified low on `chg_pin` (status bit 10), turns off `chg_on` only and leaves `dsg_on` on.
- R2: An undervoltage fault (index 1), or a qualified low on `dsg_pin` (status bit 11), turns off `dsg_on` only and leaves `chg_on` on.
- R3: An open-wire fault (2), either overcurrent fault (3, 4), a short-circuit fault (5), over-temperature while discharging (7) or under-temperature while discharging (9) turns off both outputs.
- R4: Fault i becomes active only after `trip_flags[i]` has been high at N consecutive clock edges, where N is field i of `cfg_trip_dly` (bits [i*DW +: DW], and 0 is treated as 1). A single low sample restarts the count from zero.
- R5: For the non-overcurrent faults, an active fault clears only after `rec_flags[i]` has been high at M consecutive clock edges, where M is field i of `cfg_rec_dly` (0 is treated as 1).
- R6: A pin low must be seen at `cfg_pin_dly` consecutive edges before it counts as a fault. A pin high must be seen at `cfg_pin_dly` consecutive edges before that fault clears.
- R7: With `cfg_oc_mode` = 0 (timer), an overcurrent or short-circuit fault clears on the edge after it has been active for `cfg_oc_time` edges.
- R8: With `cfg_oc_mode` = 1 (load), such a fault clears on the first edge at which `load_gone` is high, regardless of the timer.
- R9: With `cfg_oc_mode` = 2 or 3 (both), such a fault clears only on an edge where the timer has expired and `load_gone` is high.
- R10: While several faults are active, an output turns back on only when every fault that affects it has cleared.
- R11: Both outputs are off while `rst` is high and in the first cycle after it falls.
- R12: `fault_status` bit i is set one cycle after fault i is active, using the indices above with 10 = charge pin and 11 = discharge pin. It stays set until a `status_clr` pulse, and a bit whose fault is still active is set again at once.
- R13: Changes to any configuration input while `rst` is low have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| trip_flags | input | 10 | Per-condition trip comparator flags |
| rec_flags | input | 10 | Per-condition recovery (hysteresis) flags; bits 3 to 5 unused |
| chg_pin | input | 1 | External charge enable, active high |
| dsg_pin | input | 1 | External discharge enable, active high |
| load_gone | input | 1 | Load-removal detected |
| cfg_trip_dly | input | 10*DW | Trip delay per condition, field i at [i*DW +: DW] |
| cfg_rec_dly | input | 10*DW | Recovery delay per condition |
| cfg_pin_dly | input | DW | Deglitch length for both enable pins |
| cfg_oc_time | input | TW | Overcurrent recovery timer length |
| cfg_oc_mode | input | 2 | Overcurrent recovery mode: 0 timer, 1 load, 2/3 both |
| status_clr | input | 1 | Clears the sticky status register |
| chg_on | output | 1 | Charge FET enable |
| dsg_on | output | 1 | Discharge FET enable |
| fault_status | output | 12 | Sticky fault status, one bit per fault class |

## Verification
The assertions assume that configuration is stable for at least one cycle of reset, and that reset is held long enough for every state register to load. They also assume that the comparator flags are synchronous to the clock. The stimulus holds reset for several cycles and drives every input only on the falling edge. It keeps a condition's trip flag and recovery flag mutually exclusive, as real hysteresis comparators would. Overcurrent trip flags are dropped once the fault is active, so that a cleared fault does not trip again within the observation window.

// File: rtl/bpfc_pkg.sv
package bpfc_pkg;

    localparam int NTHR = 10;
    localparam int NFLT = 12;

    localparam int F_OV   = 0;
    localparam int F_UV   = 1;
    localparam int F_OW   = 2;
    localparam int F_OC1  = 3;
    localparam int F_OC2  = 4;
    localparam int F_SC   = 5;
    localparam int F_OTC  = 6;
    localparam int F_OTD  = 7;
    localparam int F_UTC  = 8;
    localparam int F_UTD  = 9;
    localparam int F_CPIN = 10;
    localparam int F_DPIN = 11;

    // Which fault classes gate which FET
    localparam logic [NFLT-1:0] CHG_MASK = 12'b0111_1111_1101;
    localparam logic [NFLT-1:0] DSG_MASK = 12'b1010_1011_1110;

    typedef enum logic [1:0] {
        OCR_TIMER = 2'd0,
        OCR_LOAD  = 2'd1,
        OCR_BOTH  = 2'd2,
        OCR_BOTH2 = 2'd3
    } ocr_mode_e;

    typedef struct packed {
        logic chg;
        logic dsg;
    } fet_en_t;

    function automatic bit is_oc(input int idx);
        return (idx == F_OC1) || (idx == F_OC2) || (idx == F_SC);
    endfunction

endpackage

// File: rtl/bpfc_qual.sv
module bpfc_qual #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trip_cond,
    input  logic          rec_cond,
    input  logic [DW-1:0] trip_dly,
    input  logic [DW-1:0] rec_dly,
    output logic          active
);
    localparam logic [DW:0] ONE = {{DW{1'b0}}, 1'b1};

    logic [DW-1:0] cnt;
    logic [DW:0]   cnt_inc;
    logic [DW:0]   lim;
    logic          cond;

    always_comb begin
        cond    = active ? rec_cond : trip_cond;
        lim     = {1'b0, (active ? rec_dly : trip_dly)};
        if (lim == '0) lim = ONE;
        cnt_inc = {1'b0, cnt} + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (cnt_inc >= lim) begin
            active <= ~active;
            cnt    <= '0;
        end else begin
            cnt <= cnt_inc[DW-1:0];
        end
    end

    assert_trip_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(trip_cond));

    assert_rec_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(rec_cond));

endmodule

// File: rtl/bpfc_oc_rec.sv
module bpfc_oc_rec
    import bpfc_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fault_active,
    input  logic          load_gone,
    input  logic [TW-1:0] limit,
    input  ocr_mode_e     mode,
    output logic          rec_ok
);
    localparam logic [TW:0] ONE = {{TW{1'b0}}, 1'b1};

    logic [TW-1:0] tmr;
    logic [TW:0]   tmr_inc;
    logic          done;

    assign tmr_inc = {1'b0, tmr} + ONE;

    always_ff @(posedge clk) begin
        if (rst || !fault_active) begin
            tmr  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            tmr <= tmr_inc[TW-1:0];
            if (tmr_inc >= {1'b0, limit}) done <= 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            OCR_TIMER: rec_ok = done;
            OCR_LOAD:  rec_ok = load_gone;
            default:   rec_ok = done && load_gone;
        endcase
    end

    assert_timer_follows_fault_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(fault_active));

endmodule

// File: rtl/bpfc_fet_map.sv
module bpfc_fet_map
    import bpfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ready,
    input  logic [NFLT-1:0] active,
    output fet_en_t         fet
);
    logic [NFLT-1:0] chg_hit;
    logic [NFLT-1:0] dsg_hit;

    for (genvar i = 0; i < NFLT; i++) begin : g_map
        assign chg_hit[i] = active[i] & CHG_MASK[i];
        assign dsg_hit[i] = active[i] & DSG_MASK[i];
    end

    assign fet.chg = ready & ~|chg_hit;
    assign fet.dsg = ready & ~|dsg_hit;

    assert_chg_only_R1: assert property (@(posedge clk) disable iff (rst)
        (active[F_OV] || active[F_CPIN]) |-> !fet.chg);

    assert_dsg_only_R2: assert property (@(posedge clk) disable iff (rst)
        (active[F_UV] || active[F_DPIN]) |-> !fet.dsg);

    assert_both_off_R3: assert property (@(posedge clk) disable iff (rst)
        (active[F_OW] || active[F_SC] || active[F_OTD]) |-> (!fet.chg && !fet.dsg));

endmodule

// File: rtl/bpfc_top.sv
module bpfc_top
    import bpfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NTHR-1:0]    trip_flags,
    input  logic [NTHR-1:0]    rec_flags,
    input  logic               chg_pin,
    input  logic               dsg_pin,
    input  logic               load_gone,
    input  logic [NTHR*DW-1:0] cfg_trip_dly,
    input  logic [NTHR*DW-1:0] cfg_rec_dly,
    input  logic [DW-1:0]      cfg_pin_dly,
    input  logic [TW-1:0]      cfg_oc_time,
    input  logic [1:0]         cfg_oc_mode,
    input  logic               status_clr,
    output logic               chg_on,
    output logic               dsg_on,
    output logic [NFLT-1:0]    fault_status
);
    localparam logic [DW-1:0] OC_REC_DLY = {{(DW-1){1'b0}}, 1'b1};

    // Configuration captured during reset
    logic [NTHR*DW-1:0] trip_q;
    logic [NTHR*DW-1:0] rec_q;
    logic [DW-1:0]      pin_q;
    logic [TW-1:0]      oct_q;
    ocr_mode_e          mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= cfg_trip_dly;
            rec_q  <= cfg_rec_dly;
            pin_q  <= cfg_pin_dly;
            oct_q  <= cfg_oc_time;
            mode_q <= ocr_mode_e'(cfg_oc_mode);
        end
    end

    // Two-stage release so that the first post-reset cycle keeps FETs off
    logic rdy_s1;
    logic ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_s1 <= 1'b0;
            ready  <= 1'b0;
        end else begin
            rdy_s1 <= 1'b1;
            ready  <= rdy_s1;
        end
    end

    logic [NFLT-1:0] active;

    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        if (is_oc(i)) begin : g_oc
            logic oc_ok;
            bpfc_oc_rec #(.TW(TW)) u_ocr (
                .clk          (clk),
                .rst          (rst),
                .fault_active (active[i]),
                .load_gone    (load_gone),
                .limit        (oct_q),
                .mode         (mode_q),
                .rec_ok       (oc_ok)
            );
            bpfc_qual #(.DW(DW)) u_q (
                .clk       (clk),
                .rst       (rst),
                .trip_cond (trip_flags[i]),
                .rec_cond  (oc_ok),
                .trip_dly  (trip_q[i*DW +: DW]),
                .rec_dly   (OC_REC_DLY),
                .active    (active[i])
            );
        end else begin : g_lvl
            bpfc_qual #(.DW(DW)) u_q (
                .clk       (clk),
                .rst       (rst),
                .trip_cond (trip_flags[i]),
                .rec_cond  (rec_flags[i]),
                .trip_dly  (trip_q[i*DW +: DW]),
                .rec_dly   (rec_q[i*DW +: DW]),
                .active    (active[i])
            );
        end
    end

    bpfc_qual #(.DW(DW)) u_cpin (
        .clk       (clk),
        .rst       (rst),
        .trip_cond (~chg_pin),
        .rec_cond  (chg_pin),
        .trip_dly  (pin_q),
        .rec_dly   (pin_q),
        .active    (active[F_CPIN])
    );

    bpfc_qual #(.DW(DW)) u_dpin (
        .clk       (clk),
        .rst       (rst),
        .trip_cond (~dsg_pin),
        .rec_cond  (dsg_pin),
        .trip_dly  (pin_q),
        .rec_dly   (pin_q),
        .active    (active[F_DPIN])
    );

    fet_en_t fet;

    bpfc_fet_map u_map (
        .clk    (clk),
        .rst    (rst),
        .ready  (ready),
        .active (active),
        .fet    (fet)
    );

    assign chg_on = fet.chg;
    assign dsg_on = fet.dsg;

    always_ff @(posedge clk) begin
        if (rst) fault_status <= '0;
        else     fault_status <= (status_clr ? '0 : fault_status) | active;
    end

    assert_reset_fets_off_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!chg_on && !dsg_on));

    assert_status_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        ((fault_status & $past(active)) == $past(active)));

    assert_cfg_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(trip_q) && $stable(rec_q) && $stable(pin_q)
                         && $stable(oct_q) && $stable(mode_q)));

endmodule

// File: tb/bpfc_top_tb.sv
`timescale 1ns/1ps
module bpfc_top_tb;
    import bpfc_pkg::*;

    localparam int DW = 8;
    localparam int TW = 12;
    localparam int TD = 4;   // trip delay used everywhere
    localparam int RD = 6;   // recovery delay used everywhere
    localparam int PD = 3;   // pin deglitch
    localparam int OT = 10;  // overcurrent timer

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NTHR-1:0]    trip_flags = '0;
    logic [NTHR-1:0]    rec_flags = '1;
    logic               chg_pin = 1'b1;
    logic               dsg_pin = 1'b1;
    logic               load_gone = 1'b0;
    logic [NTHR*DW-1:0] cfg_trip_dly;
    logic [NTHR*DW-1:0] cfg_rec_dly;
    logic [DW-1:0]      cfg_pin_dly = DW'(PD);
    logic [TW-1:0]      cfg_oc_time = TW'(OT);
    logic [1:0]         cfg_oc_mode = 2'd0;
    logic               status_clr = 1'b0;
    logic               chg_on, dsg_on;
    logic [NFLT-1:0]    fault_status;

    always #4 clk = ~clk;

    bpfc_top #(.DW(DW), .TW(TW)) u_dut (
        .clk, .rst, .trip_flags, .rec_flags, .chg_pin, .dsg_pin, .load_gone,
        .cfg_trip_dly, .cfg_rec_dly, .cfg_pin_dly, .cfg_oc_time, .cfg_oc_mode,
        .status_clr, .chg_on, .dsg_on, .fault_status
    );

    typedef struct {
        bit              is_st;
        logic            chg;
        logic            dsg;
        logic [NFLT-1:0] st;
        string           req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_fet(input logic c, input logic d, input string r);
        exp_t e;
        e.is_st = 0; e.chg = c; e.dsg = d; e.st = '0; e.req = r;
        q.push_back(e);
    endtask

    task automatic exp_st(input logic [NFLT-1:0] s, input string r);
        exp_t e;
        e.is_st = 1; e.chg = 0; e.dsg = 0; e.st = s; e.req = r;
        q.push_back(e);
    endtask

    // Monitor: compares queued expectations a little after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (e.is_st) begin
                    if (fault_status !== e.st) begin
                        n_bad++;
                        $display("FAIL %s: status actual=%b expected=%b", e.req, fault_status, e.st);
                    end
                end else if (chg_on !== e.chg || dsg_on !== e.dsg) begin
                    n_bad++;
                    $display("FAIL %s: chg/dsg actual=%b%b expected=%b%b",
                             e.req, chg_on, dsg_on, e.chg, e.dsg);
                end
            end
        end
    end

    task automatic do_reset(input logic [1:0] mode);
        rst = 1'b1;
        cfg_oc_mode = mode;
        cyc(3);
        rst = 1'b0;
        cyc(2);
    endtask

    task automatic set_fault(input int i, input bit on);
        trip_flags[i] = on;
        rec_flags[i]  = ~on;
    endtask

    initial begin
        for (int i = 0; i < NTHR; i++) begin
            cfg_trip_dly[i*DW +: DW] = DW'(TD);
            cfg_rec_dly[i*DW +: DW]  = DW'(RD);
        end
        // R11: reset state
        cyc(3);
        exp_fet(0, 0, "R11 during reset");
        rst = 1'b0;
        cyc(1); exp_fet(0, 0, "R11 first cycle after reset");
        cyc(1); exp_fet(1, 1, "R11 released");
        exp_st('0, "R12 status clear after reset");

        // R4: glitch restarts the count
        set_fault(F_OTC, 1); cyc(3);
        trip_flags[F_OTC] = 0; cyc(1);
        trip_flags[F_OTC] = 1; cyc(TD-1);
        exp_fet(1, 1, "R4 not yet tripped after restart");
        cyc(1); exp_fet(0, 1, "R1 OTC charge only");
        cyc(1); exp_st(12'(1) << F_OTC, "R12 OTC bit set");
        // R5: recovery delay
        set_fault(F_OTC, 0); cyc(RD-1);
        exp_fet(0, 1, "R5 still off before recovery delay");
        cyc(1); exp_fet(1, 1, "R5 recovered");
        // R12: clear strobe
        status_clr = 1; cyc(1); status_clr = 0;
        exp_st('0, "R12 cleared by strobe");

        // R1 overvoltage
        set_fault(F_OV, 1); cyc(TD); exp_fet(0, 1, "R1 OV charge only");
        set_fault(F_OV, 0); cyc(RD); exp_fet(1, 1, "R1 OV recovered");
        // R2 undervoltage
        set_fault(F_UV, 1); cyc(TD); exp_fet(1, 0, "R2 UV discharge only");
        set_fault(F_UV, 0); cyc(RD); exp_fet(1, 1, "R2 UV recovered");
        // R3 over-temperature in discharge
        set_fault(F_OTD, 1); cyc(TD); exp_fet(0, 0, "R3 OTD both off");
        set_fault(F_OTD, 0); cyc(RD); exp_fet(1, 1, "R3 OTD recovered");

        // R10: two faults overlap
        set_fault(F_OV, 1); set_fault(F_UTD, 1); cyc(TD);
        exp_fet(0, 0, "R10 OV+UTD both off");
        set_fault(F_UTD, 0); cyc(RD);
        exp_fet(0, 1, "R10 charge held off by OV");
        set_fault(F_OV, 0); cyc(RD);
        exp_fet(1, 1, "R10 all cleared");

        // R6: pins
        chg_pin = 0; cyc(PD-1); exp_fet(1, 1, "R6 charge pin deglitching");
        cyc(1); exp_fet(0, 1, "R6 charge pin low acted");
        chg_pin = 1; cyc(PD-1); exp_fet(0, 1, "R6 charge pin high deglitching");
        cyc(1); exp_fet(1, 1, "R6 charge pin recovered");
        dsg_pin = 0; cyc(PD); exp_fet(1, 0, "R2 discharge pin low");
        dsg_pin = 1; cyc(PD); exp_fet(1, 1, "R6 discharge pin recovered");
        exp_st((12'(1) << F_OV) | (12'(1) << F_UV) | (12'(1) << F_OTD) | (12'(1) << F_UTD)
               | (12'(1) << F_CPIN) | (12'(1) << F_DPIN), "R12 sticky accumulation");

        // R7: timer recovery
        trip_flags[F_OC1] = 1; cyc(TD); exp_fet(0, 0, "R3 OC1 both off");
        trip_flags[F_OC1] = 0; cyc(OT); exp_fet(0, 0, "R7 timer not expired");
        cyc(1); exp_fet(1, 1, "R7 timer recovery");

        // R13: trip delay change without reset is ignored
        cfg_trip_dly[F_OW*DW +: DW] = DW'(1);
        cfg_oc_mode = 2'd1;
        set_fault(F_OW, 1); cyc(TD-1); exp_fet(1, 1, "R13 old trip delay still used");
        cyc(1); exp_fet(0, 0, "R3 OW both off");
        set_fault(F_OW, 0); cyc(RD); exp_fet(1, 1, "R3 OW recovered");
        cfg_trip_dly[F_OW*DW +: DW] = DW'(TD);

        // R8: load-removal mode
        do_reset(2'd1);
        trip_flags[F_SC] = 1; cyc(TD); exp_fet(0, 0, "R3 SC both off");
        trip_flags[F_SC] = 0; cyc(OT + 5); exp_fet(0, 0, "R8 timer alone does not clear");
        load_gone = 1; cyc(1); exp_fet(1, 1, "R8 load removal clears");
        load_gone = 0;

        // R9: both mode
        do_reset(2'd2);
        trip_flags[F_OC2] = 1; cyc(TD); exp_fet(0, 0, "R3 OC2 both off");
        trip_flags[F_OC2] = 0; load_gone = 1; cyc(OT);
        exp_fet(0, 0, "R9 load alone does not clear");
        cyc(1); exp_fet(1, 1, "R9 timer plus load clears");
        load_gone = 0;
        trip_flags[F_OC2] = 1; cyc(TD); exp_fet(0, 0, "R9 OC2 retrip");
        trip_flags[F_OC2] = 0; cyc(OT + 2); exp_fet(0, 0, "R9 timer alone does not clear");
        load_gone = 1; cyc(1); exp_fet(1, 1, "R9 load after timer clears");
        load_gone = 0;

        cyc(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule